// File: doc/BRIEF.md
# External Interrupt Sense and Latch

This block conditions four external interrupt request pins before they reach an interrupt controller. Each pin passes through a two-stage synchroniser. A sense stage then treats it as an active-high level, an active-low level, a rising edge or a falling edge, and the choice is made per line. In the edge modes a sticky latch records the event until software clears it.

A single 32-bit control word holds all configuration. It is written and read through a plain register port. The word contains the sense fields, the per-line enables, a master enable, a routing select for the critical request, and write-one-to-clear bits for the edge latches.

Each line raises a request only when its own enable and the master enable are both set. Line 0 drives the critical request level. Lines 1 to 3 drive sources 1 to 3 of the main controller.

Top module: `ext_irq_cond`

## Requirements
- R1: After reset the control word reads 0, the critical routing output is 0, and no request output is active.
- R2: The control word places the sense field of line n at bits [23-2n:22-2n], the enable of line n at bit 11-n, the master enable at bit 12 and the critical routing select at bit 0. These fields read back as written, and every other bit reads 0.
- R3: Bits 27-n are latch clear strobes for line n and always read back as 0.
- R4: Sense code 00 (active-high level) makes an enabled line's request follow the synchronised pin directly, with no latch.
- R5: Sense code 11 (active-low level) makes an enabled line's request follow the inverted synchronised pin.
- R6: Sense code 01 (rising edge) sets the line's latch on a 0-to-1 change of the synchronised pin. The latch and the request stay set after the pin falls again.
- R7: Sense code 10 (falling edge) sets the line's latch on a 1-to-0 change of the synchronised pin.
- R8: A control write with bit 27-n set clears the edge latch of line n on that clock edge. Lines whose clear bit is 0 keep their latches.
- R9: If a latch clear and a new selected edge on the same line fall on the same clock edge, the latch stays set.
- R10: While the master enable (bit 12) is 0, all request outputs are 0.
- R11: While a line's enable bit is 0, its request output is 0. Its edge latch still captures edges, so enabling the line later shows the stored event.
- R12: Line 0 drives crit_req and lines 1, 2 and 3 drive main_req[0], [1] and [2]. A pin change appears on a level-mode request after the second rising clock edge.
- R13: The crit_route_normal output equals control bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read data |
| irq_pin | input | 4 | Asynchronous external request pins, bit n is line n |
| crit_req | output | 1 | Critical request level from line 0 |
| main_req | output | 3 | Requests to main sources 1 to 3 from lines 1 to 3 |
| crit_route_normal | output | 1 | Normal routing select for the critical request |

## Verification
On every cycle the assertions check four things. The clear strobes read as zero. The master enable and the per-line enables gate the requests. A level-mode request matches the synchronised pin in the right polarity. An enabled edge latch never drops without a clear write or a change of configuration.

Only the bench scenarios can show the rest:
- the two-cycle synchroniser latency;
- that a rising or falling edge actually sets a latch;
- that a clear arriving together with a new edge loses;
- that an edge captured while a line is disabled shows up once the line is enabled.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  localparam int CTL_W     = 32;
  localparam int N_LINES   = 4;
  localparam int MEE_BIT   = 12;
  localparam int ROUTE_BIT = 0;

  typedef enum logic [1:0] {
    SENSE_LVL_HI = 2'b00,
    SENSE_RISE   = 2'b01,
    SENSE_FALL   = 2'b10,
    SENSE_LVL_LO = 2'b11
  } sense_e;

  // low bit of the 2-bit sense field of line n
  function automatic int sense_lsb(input int n);
    return 22 - 2 * n;
  endfunction

  function automatic int en_bit(input int n);
    return 11 - n;
  endfunction

  function automatic int clr_bit(input int n);
    return 27 - n;
  endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/ext_irq_ctrl_reg.sv
module ext_irq_ctrl_reg
  import ext_irq_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [CTL_W-1:0]        wdata,
  output logic [N_LINES-1:0][1:0] sense,
  output logic [N_LINES-1:0]      en,
  output logic                    mee,
  output logic                    route,
  output logic [N_LINES-1:0]      clr,
  output logic [CTL_W-1:0]        rdata
);

  logic [N_LINES-1:0][1:0] sense_d;
  logic [N_LINES-1:0]      en_d;
  logic                    mee_d;
  logic                    route_d;

  always_comb begin
    sense_d = sense;
    en_d    = en;
    mee_d   = mee;
    route_d = route;
    clr     = '0;
    if (wr_en) begin
      for (int n = 0; n < N_LINES; n++) begin
        sense_d[n] = wdata[sense_lsb(n) +: 2];
        en_d[n]    = wdata[en_bit(n)];
        clr[n]     = wdata[clr_bit(n)];
      end
      mee_d   = wdata[MEE_BIT];
      route_d = wdata[ROUTE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense <= '0;
      en    <= '0;
      mee   <= 1'b0;
      route <= 1'b0;
    end else if (wr_en) begin
      sense <= sense_d;
      en    <= en_d;
      mee   <= mee_d;
      route <= route_d;
    end
  end

  always_comb begin
    rdata = '0;
    for (int n = 0; n < N_LINES; n++) begin
      rdata[sense_lsb(n) +: 2] = sense[n];
      rdata[en_bit(n)]         = en[n];
    end
    rdata[MEE_BIT]   = mee;
    rdata[ROUTE_BIT] = route;
  end

endmodule

// File: rtl/ext_irq_line.sv
module ext_irq_line
  import ext_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   smp,
  input  sense_e sense,
  input  logic   en,
  input  logic   mee,
  input  logic   clr,
  output logic   req
);

  logic prev_q;
  logic latch_q, latch_d;
  logic is_edge, det, lvl;

  always_comb begin
    is_edge = (sense == SENSE_RISE) || (sense == SENSE_FALL);
    det     = (sense == SENSE_RISE) ? (smp & ~prev_q) : (~smp & prev_q);
    lvl     = (sense == SENSE_LVL_LO) ? ~smp : smp;
    // a new edge wins over a clear in the same cycle
    latch_d = is_edge & (det | (latch_q & ~clr));
    req     = en & mee & (is_edge ? latch_q : lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q  <= smp;
      latch_q <= latch_d;
    end
  end

endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [CTL_W-1:0] reg_wdata,
  output logic [CTL_W-1:0] reg_rdata,
  input  logic [3:0]       irq_pin,
  output logic             crit_req,
  output logic [2:0]       main_req,
  output logic             crit_route_normal
);

  logic [N_LINES-1:0][1:0] sense;
  logic [N_LINES-1:0]      en;
  logic [N_LINES-1:0]      clr;
  logic                    mee;
  logic [N_LINES-1:0]      pin_sync;
  logic [N_LINES-1:0]      line_req;

  ext_irq_ctrl_reg u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr),
    .wdata (reg_wdata),
    .sense (sense),
    .en    (en),
    .mee   (mee),
    .route (crit_route_normal),
    .clr   (clr),
    .rdata (reg_rdata)
  );

  ext_irq_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (irq_pin),
    .q     (pin_sync)
  );

  for (genvar n = 0; n < N_LINES; n++) begin : g_line
    ext_irq_line u_line (
      .clk   (clk),
      .rst_n (rst_n),
      .smp   (pin_sync[n]),
      .sense (sense_e'(sense[n])),
      .en    (en[n]),
      .mee   (mee),
      .clr   (clr[n]),
      .req   (line_req[n])
    );
  end

  assign crit_req = line_req[0];
  assign main_req = line_req[3:1];

endmodule

// File: rtl/ext_irq_cond_chk.sv
module ext_irq_cond_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        crit_req,
  input logic [2:0]  main_req,
  input logic [3:0]  smp
);

  logic [3:0] req;
  assign req = {main_req, crit_req};

  // R3
  clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[27:24] == 4'b0);

  // R10
  master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[12] |-> (req == 4'b0));

  for (genvar n = 0; n < 4; n++) begin : g_ln
    // R11
    line_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[11-n] |-> !req[n]);

    // R4
    level_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[23-2*n -: 2] == 2'b00 && reg_rdata[11-n] && reg_rdata[12])
        |-> (req[n] == smp[n]));

    // R5
    level_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[23-2*n -: 2] == 2'b11 && reg_rdata[11-n] && reg_rdata[12])
        |-> (req[n] == !smp[n]));

    // R6
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((reg_rdata[23-2*n -: 2] == 2'b01 || reg_rdata[23-2*n -: 2] == 2'b10)
        && $past(req[n]) && $stable(reg_rdata)
        && !$past(reg_wr && reg_wdata[27-n])) |-> req[n]);
  end

endmodule

bind ext_irq_cond ext_irq_cond_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .crit_req  (crit_req),
  .main_req  (main_req),
  .smp       (pin_sync)
);

// File: tb/ext_irq_cond_tb.sv
module ext_irq_cond_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  irq_pin = '0;
  logic        crit_req;
  logic [2:0]  main_req;
  logic        crit_route_normal;
  int          n_chk = 0;
  int          n_bad = 0;

  always #10 clk = ~clk;

  ext_irq_cond u_dut (
    .clk               (clk),
    .rst_n             (rst_n),
    .reg_wr            (reg_wr),
    .reg_wdata         (reg_wdata),
    .reg_rdata         (reg_rdata),
    .irq_pin           (irq_pin),
    .crit_req          (crit_req),
    .main_req          (main_req),
    .crit_route_normal (crit_route_normal)
  );

  function automatic logic [3:0] reqv();
    return {main_req, crit_req};
  endfunction

  // sense codes: line n at sp[2n+1:2n]
  function automatic logic [31:0] mk(input logic [7:0] sp, input logic [3:0] en,
                                     input logic mee, input logic route,
                                     input logic [3:0] clr);
    logic [31:0] v;
    v = '0;
    for (int n = 0; n < 4; n++) begin
      v[23-2*n -: 2] = sp[2*n +: 2];
      v[11-n]        = en[n];
      v[27-n]        = clr[n];
    end
    v[12] = mee;
    v[0]  = route;
    return v;
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic pins(input logic [3:0] p);
    @(negedge clk);
    irq_pin = p;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 rdata", reg_rdata, 32'h0);
    chk("R1 req", {28'h0, reqv()}, 32'h0);
    chk("R1 route", {31'h0, crit_route_normal}, 32'h0);
  endtask

  task automatic t_regmap();
    wr(mk(8'b00_11_10_01, 4'b1010, 1'b1, 1'b1, 4'hF) | 32'hC000_20F2);
    chk("R2 fields", reg_rdata, mk(8'b00_11_10_01, 4'b1010, 1'b1, 1'b1, 4'h0));
    chk("R3 clear bits", {28'h0, reg_rdata[27:24]}, 32'h0);
    chk("R13 route", {31'h0, crit_route_normal}, 32'h1);
    wr(32'h0);
    chk("R13 route off", {31'h0, crit_route_normal}, 32'h0);
  endtask

  task automatic t_level_hi();
    wr(mk(8'h00, 4'hF, 1'b1, 1'b0, 4'h0));
    pins(4'b0101);
    chk("R4 R12 pattern a", {28'h0, reqv()}, 32'h5);
    pins(4'b1010);
    chk("R4 R12 pattern b", {28'h0, reqv()}, 32'hA);
    @(negedge clk); irq_pin = 4'b0001;
    @(posedge clk); @(negedge clk);
    chk("R12 one edge", {28'h0, reqv()}, 32'hA);
    @(posedge clk); @(negedge clk);
    chk("R12 two edges", {28'h0, reqv()}, 32'h1);
  endtask

  task automatic t_level_lo();
    wr(mk(8'hFF, 4'hF, 1'b1, 1'b0, 4'h0));
    pins(4'b0000);
    chk("R5 all low", {28'h0, reqv()}, 32'hF);
    pins(4'b0110);
    chk("R5 mixed", {28'h0, reqv()}, 32'h9);
  endtask

  task automatic t_rise();
    pins(4'b0000);
    wr(mk(8'h55, 4'hF, 1'b1, 1'b0, 4'h0));
    chk("R6 idle", {28'h0, reqv()}, 32'h0);
    pins(4'b0011);
    chk("R6 set", {28'h0, reqv()}, 32'h3);
    pins(4'b0000);
    chk("R6 hold", {28'h0, reqv()}, 32'h3);
    wr(mk(8'h55, 4'hF, 1'b1, 1'b0, 4'b0001));
    chk("R8 clear line0 only", {28'h0, reqv()}, 32'h2);
    wr(mk(8'h55, 4'hF, 1'b1, 1'b0, 4'b0010));
    chk("R8 clear line1", {28'h0, reqv()}, 32'h0);
  endtask

  task automatic t_fall();
    wr(mk(8'h00, 4'hF, 1'b1, 1'b0, 4'h0));
    pins(4'b1111);
    wr(mk(8'hAA, 4'hF, 1'b1, 1'b0, 4'h0));
    chk("R7 idle", {28'h0, reqv()}, 32'h0);
    pins(4'b1100);
    chk("R7 set", {28'h0, reqv()}, 32'h3);
    pins(4'b1111);
    chk("R7 no set on rise", {28'h0, reqv()}, 32'h3);
  endtask

  task automatic t_edge_wins();
    wr(mk(8'h00, 4'hF, 1'b1, 1'b0, 4'h0));
    pins(4'b0000);
    wr(mk(8'h55, 4'hF, 1'b1, 1'b0, 4'h0));
    @(negedge clk); irq_pin = 4'b0100;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = mk(8'h55, 4'hF, 1'b1, 1'b0, 4'b0100);
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
    chk("R9 edge wins", {28'h0, reqv()}, 32'h4);
    @(posedge clk); @(negedge clk);
    chk("R9 still set", {28'h0, reqv()}, 32'h4);
    wr(mk(8'h55, 4'hF, 1'b1, 1'b0, 4'b0100));
    chk("R8 later clear", {28'h0, reqv()}, 32'h0);
  endtask

  task automatic t_master();
    wr(mk(8'h00, 4'hF, 1'b0, 1'b0, 4'h0));
    pins(4'b1111);
    chk("R10 master off", {28'h0, reqv()}, 32'h0);
    wr(mk(8'h00, 4'hF, 1'b1, 1'b0, 4'h0));
    chk("R10 master on", {28'h0, reqv()}, 32'hF);
  endtask

  task automatic t_line_en();
    pins(4'b0000);
    wr(mk(8'h55, 4'h0, 1'b1, 1'b0, 4'h0));
    pins(4'b1000);
    chk("R11 disabled", {28'h0, reqv()}, 32'h0);
    wr(mk(8'h55, 4'b1000, 1'b1, 1'b0, 4'h0));
    chk("R11 enable shows latch", {28'h0, reqv()}, 32'h8);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_level_hi();
    t_level_lo();
    t_rise();
    t_fall();
    t_edge_wins();
    t_master();
    t_line_en();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule